// File: doc/BRIEF.md
# Phase-Directed Cache Way Controller

This block decides how many ways of a set-associative data cache stay powered. At each interval boundary it receives the ID of the program phase that is starting. It first refines the way count stored for the phase that just ended, using that interval's miss rate. It then applies the count stored for the incoming phase. The result is a per-way enable mask that gates the precharge and sense-amplifier logic of each way. Ways switch off from the highest index downward and switch back on in reverse order.

Blocks held in a way that is being switched off are written back into a small fully associative victim buffer. They are not flushed or moved into a live way. Every cache miss searches this buffer. A hit returns the block one cycle later and frees the entry. While a writeback is in progress the mask is frozen, and a pending change is applied once the transfer ends.

Top module: `way_ctrl_top`

## Requirements
- R1: During and after reset, with no boundary seen, all NUM_WAYS ways are enabled and `vb_hit_o` is 0. Every phase entry starts at NUM_WAYS ways.
- R2: `way_en_o[i]` is 1 exactly when i < the current way count, so the enabled ways are always 0..count-1 and way 0 is always on.
- R3: At a boundary, if the closing interval had misses×LO_DEN < accesses×LO_NUM, the closing phase's stored count drops by one, but never below 1.
- R4: Otherwise, if misses×HI_DEN > accesses×HI_NUM, the closing phase's stored count rises by one, but never above NUM_WAYS. An interval with no accesses leaves the count unchanged.
- R5: The mask applies the stored count of the phase ID given with the boundary. A phase that returns gets back the count it was left with. The first boundary after reset refines nothing.
- R6: The mask changes only at the clock edge that samples `phase_valid_i`, or at the edge that releases a held change. It is therefore visible from the cycle after the strobe.
- R7: While `evict_valid_i` is high the mask does not change. A change requested during that time is kept, and it is applied at the first edge where `evict_valid_i` is low. A later boundary replaces it.
- R8: Each cycle with `evict_valid_i` high writes the address and data into the victim buffer in FIFO order, overwriting the oldest slot once all VB_DEPTH slots have been used.
- R9: A cycle with `miss_i` high searches the buffer for `miss_addr_i`. On a match, `vb_hit_o` is 1 in the next cycle with the stored data on `vb_data_o`, and the entry becomes invalid. Without a match, `vb_hit_o` is 0.
- R10: Access and miss counts restart at each boundary. Strobes in the boundary cycle belong to the new interval, and the counts saturate at their maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_valid_i | input | 1 | Interval boundary strobe |
| phase_id_i | input | PHASE_W | Phase starting at this boundary |
| access_i | input | 1 | One cache access this cycle |
| miss_i | input | 1 | One cache miss this cycle; triggers victim search |
| miss_addr_i | input | ADDR_W | Block address of the miss |
| evict_valid_i | input | 1 | Writeback from a way being disabled |
| evict_addr_i | input | ADDR_W | Block address of the writeback |
| evict_data_i | input | DATA_W | Block data of the writeback |
| way_en_o | output | NUM_WAYS | Per-way power enable |
| vb_hit_o | output | 1 | Victim buffer hit for the previous miss |
| vb_data_o | output | DATA_W | Data of the hit entry |

## Verification
The bench builds the block with four ways, four phases, 8-bit interval counters, a four-entry victim buffer and thresholds of 1/16 and 1/4. With four ways, a few short intervals are enough to walk the count from the ceiling down to the floor and back up. With only four slots, a six-entry writeback burst wraps the FIFO and overwrites the oldest entries. The 8-bit counters let one long interval reach saturation. With two phase bits, several phases can be interleaved so that the stored counts are restored from the table rather than carried over.

// File: rtl/way_ctrl_pkg.sv
`timescale 1ns/1ps
package way_ctrl_pkg;
  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_DOWN = 2'd1,
    ADJ_UP   = 2'd2
  } adj_e;
endpackage

// File: rtl/way_ctrl_rate.sv
`timescale 1ns/1ps
module way_ctrl_rate
  import way_ctrl_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LO_NUM = 1,
  parameter int LO_DEN = 16,
  parameter int HI_NUM = 1,
  parameter int HI_DEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  input  logic miss_i,
  input  logic boundary_i,
  output adj_e adj_o
);
  localparam int PW = 2 * CNT_W + 1;

  logic [CNT_W-1:0] acc_q, miss_q;
  logic [PW-1:0] m_lo, a_lo, m_hi, a_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      miss_q <= '0;
    end else if (boundary_i) begin
      acc_q  <= CNT_W'(access_i);
      miss_q <= CNT_W'(miss_i);
    end else begin
      if (access_i && acc_q != '1) acc_q <= acc_q + 1'b1;
      if (miss_i && miss_q != '1)  miss_q <= miss_q + 1'b1;
    end
  end

  // divider-free rate compare
  assign m_lo = PW'(miss_q) * PW'(LO_DEN);
  assign a_lo = PW'(acc_q)  * PW'(LO_NUM);
  assign m_hi = PW'(miss_q) * PW'(HI_DEN);
  assign a_hi = PW'(acc_q)  * PW'(HI_NUM);

  always_comb begin
    if (m_lo < a_lo)      adj_o = ADJ_DOWN;
    else if (m_hi > a_hi) adj_o = ADJ_UP;
    else                  adj_o = ADJ_HOLD;
  end

  assert_counter_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && !access_i |=> acc_q == '0);
endmodule

// File: rtl/way_ctrl_table.sv
`timescale 1ns/1ps
module way_ctrl_table
  import way_ctrl_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int PHASE_W  = 3,
  localparam int CW      = $clog2(NUM_WAYS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boundary_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  adj_e               adj_i,
  output logic [CW-1:0]      target_o
);
  localparam int NUM_PH = 1 << PHASE_W;

  logic [CW-1:0]      tab_q [NUM_PH];
  logic [PHASE_W-1:0] cur_q;
  logic               cur_vld_q;
  logic [CW-1:0]      base, refined;

  assign base = tab_q[cur_q];

  always_comb begin
    refined = base;
    if (adj_i == ADJ_DOWN && base > CW'(1))             refined = base - 1'b1;
    else if (adj_i == ADJ_UP && base < CW'(NUM_WAYS))   refined = base + 1'b1;
  end

  assign target_o = (cur_vld_q && phase_i == cur_q) ? refined : tab_q[phase_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PH; p++) tab_q[p] <= CW'(NUM_WAYS);
      cur_q     <= '0;
      cur_vld_q <= 1'b0;
    end else if (boundary_i) begin
      if (cur_vld_q) tab_q[cur_q] <= refined;
      cur_q     <= phase_i;
      cur_vld_q <= 1'b1;
    end
  end

  assert_target_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |-> (target_o >= CW'(1) && target_o <= CW'(NUM_WAYS)));
  assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && cur_vld_q && phase_i == cur_q |=> (tab_q[cur_q] + 1'b1 >= $past(base)) && (tab_q[cur_q] <= $past(base) + 1'b1));
endmodule

// File: rtl/way_ctrl_vbuf.sv
`timescale 1ns/1ps
module way_ctrl_vbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lk_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DEPTH-1:0]  vld_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [IW-1:0]     wptr_q;
  logic [DEPTH-1:0]  match;
  logic              any_match;
  logic [IW-1:0]     hit_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && addr_q[g] == lk_addr_i;
  end

  assign any_match = |match;

  always_comb begin
    hit_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) if (match[k]) hit_idx = IW'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      wptr_q <= '0;
      hit_o  <= 1'b0;
      data_o <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        addr_q[k] <= '0;
        data_q[k] <= '0;
      end
    end else begin
      hit_o <= lk_i && any_match;
      if (lk_i && any_match) begin
        data_o         <= data_q[hit_idx];
        vld_q[hit_idx] <= 1'b0;
      end
      // write after lookup so a same-slot write wins
      if (wr_i) begin
        vld_q[wptr_q]  <= 1'b1;
        addr_q[wptr_q] <= wr_addr_i;
        data_q[wptr_q] <= wr_data_i;
        wptr_q         <= (wptr_q == IW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      end
    end
  end

  assert_hit_after_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(lk_i));
  assert_ptr_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= IW'(DEPTH - 1));
endmodule

// File: rtl/way_ctrl_top.sv
`timescale 1ns/1ps
module way_ctrl_top
  import way_ctrl_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int PHASE_W  = 3,
  parameter int CNT_W    = 16,
  parameter int LO_NUM   = 1,
  parameter int LO_DEN   = 16,
  parameter int HI_NUM   = 1,
  parameter int HI_DEN   = 4,
  parameter int VB_DEPTH = 4,
  parameter int ADDR_W   = 26,
  parameter int DATA_W   = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_valid_i,
  input  logic [PHASE_W-1:0] phase_id_i,
  input  logic               access_i,
  input  logic               miss_i,
  input  logic [ADDR_W-1:0]  miss_addr_i,
  input  logic               evict_valid_i,
  input  logic [ADDR_W-1:0]  evict_addr_i,
  input  logic [DATA_W-1:0]  evict_data_i,
  output logic [NUM_WAYS-1:0] way_en_o,
  output logic               vb_hit_o,
  output logic [DATA_W-1:0]  vb_data_o
);
  localparam int CW = $clog2(NUM_WAYS + 1);

  adj_e          adj;
  logic [CW-1:0] target;
  logic [CW-1:0] cnt_q, pend_cnt_q;
  logic          pend_q;

  way_ctrl_rate #(
    .CNT_W(CNT_W), .LO_NUM(LO_NUM), .LO_DEN(LO_DEN), .HI_NUM(HI_NUM), .HI_DEN(HI_DEN)
  ) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .access_i(access_i), .miss_i(miss_i),
    .boundary_i(phase_valid_i), .adj_o(adj)
  );

  way_ctrl_table #(.NUM_WAYS(NUM_WAYS), .PHASE_W(PHASE_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni), .boundary_i(phase_valid_i),
    .phase_i(phase_id_i), .adj_i(adj), .target_o(target)
  );

  way_ctrl_vbuf #(.DEPTH(VB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vbuf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(evict_valid_i), .wr_addr_i(evict_addr_i), .wr_data_i(evict_data_i),
    .lk_i(miss_i), .lk_addr_i(miss_addr_i),
    .hit_o(vb_hit_o), .data_o(vb_data_o)
  );

  // mask held while a writeback drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= CW'(NUM_WAYS);
      pend_q     <= 1'b0;
      pend_cnt_q <= CW'(NUM_WAYS);
    end else if (phase_valid_i) begin
      if (evict_valid_i) begin
        pend_q     <= 1'b1;
        pend_cnt_q <= target;
      end else begin
        cnt_q  <= target;
        pend_q <= 1'b0;
      end
    end else if (pend_q && !evict_valid_i) begin
      cnt_q  <= pend_cnt_q;
      pend_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_mask
    assign way_en_o[w] = CW'(w) < cnt_q;
  end

  assert_mask_contig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    way_en_o[0] && (((way_en_o + 1'b1) & way_en_o) == '0));
  assert_mask_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_valid_i && !pend_q |=> $stable(way_en_o));
  assert_mask_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i |=> $stable(way_en_o));
  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q >= CW'(1) && cnt_q <= CW'(NUM_WAYS));
endmodule

// File: tb/tb_way_ctrl_top.sv
`timescale 1ns/1ps
module tb_way_ctrl_top;
  localparam int NW = 4, PW = 2, CW8 = 8, AW = 12, DW = 16, VD = 4;
  localparam int LN = 1, LD = 16, HN = 1, HD = 4;

  logic clk_i = 0, rst_ni = 0;
  logic phase_valid_i = 0, access_i = 0, miss_i = 0, evict_valid_i = 0;
  logic [PW-1:0] phase_id_i = '0;
  logic [AW-1:0] miss_addr_i = '0, evict_addr_i = '0;
  logic [DW-1:0] evict_data_i = '0;
  logic [NW-1:0] way_en_o;
  logic vb_hit_o;
  logic [DW-1:0] vb_data_o;

  way_ctrl_top #(.NUM_WAYS(NW), .PHASE_W(PW), .CNT_W(CW8), .LO_NUM(LN), .LO_DEN(LD),
    .HI_NUM(HN), .HI_DEN(HD), .VB_DEPTH(VD), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  always #2 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_cnt = NW, m_pend = 0, m_pend_cnt = NW;
  int m_tab [4] = '{NW, NW, NW, NW};
  int m_cur = 0, m_cur_vld = 0, m_acc = 0, m_miss = 0;
  bit m_vld [VD];
  int m_addr [VD], m_data [VD];
  int m_ptr = 0, m_hit = 0, m_hdata = 0;

  function automatic logic [NW-1:0] mask_of(int c);
    logic [NW-1:0] m = '0;
    for (int i = 0; i < NW; i++) if (i < c) m[i] = 1'b1;
    return m;
  endfunction

  task automatic compare(string req);
    n_cmp++;
    if (way_en_o !== mask_of(m_cnt)) begin
      n_bad++;
      $display("FAIL %s way_en_o actual=%b expected=%b", req, way_en_o, mask_of(m_cnt));
    end
    n_cmp++;
    if (vb_hit_o !== (m_hit != 0) || (m_hit != 0 && vb_data_o !== DW'(m_hdata))) begin
      n_bad++;
      $display("FAIL %s vb actual=%b/%h expected=%0d/%h", req, vb_hit_o, vb_data_o, m_hit, m_hdata);
    end
  endtask

  task automatic tick(string req);
    bit pv, ac, ms, ev;
    int pid, maddr, eaddr, edata;
    @(posedge clk_i);
    pv = phase_valid_i; ac = access_i; ms = miss_i; ev = evict_valid_i;
    pid = int'(phase_id_i); maddr = int'(miss_addr_i);
    eaddr = int'(evict_addr_i); edata = int'(evict_data_i);
    begin
      bit low, high;
      int r;
      low  = (m_miss * LD < m_acc * LN);
      high = (m_miss * HD > m_acc * HN);
      if (pv) begin
        if (m_cur_vld) begin
          r = m_tab[m_cur];
          if (low && r > 1) r--;
          else if (!low && high && r < NW) r++;
          m_tab[m_cur] = r;
        end
        m_cur = pid; m_cur_vld = 1;
        if (ev) begin m_pend = 1; m_pend_cnt = m_tab[pid]; end
        else begin m_cnt = m_tab[pid]; m_pend = 0; end
        m_acc = ac; m_miss = ms;
      end else begin
        if (m_pend && !ev) begin m_cnt = m_pend_cnt; m_pend = 0; end
        if (ac && m_acc < 255) m_acc++;
        if (ms && m_miss < 255) m_miss++;
      end
      m_hit = 0;
      if (ms) for (int k = 0; k < VD; k++)
        if (m_hit == 0 && m_vld[k] && m_addr[k] == maddr) begin
          m_hit = 1; m_hdata = m_data[k]; m_vld[k] = 0;
        end
      if (ev) begin
        m_vld[m_ptr] = 1; m_addr[m_ptr] = eaddr; m_data[m_ptr] = edata;
        m_ptr = (m_ptr + 1) % VD;
      end
    end
    @(negedge clk_i);
    compare(req);
  endtask

  task automatic boundary(int pid, string req);
    phase_valid_i = 1; phase_id_i = PW'(pid);
    tick(req);
    phase_valid_i = 0;
    tick(req);
  endtask

  task automatic interval(int n_acc, int n_miss, string req);
    for (int i = 0; i < n_acc; i++) begin
      access_i = 1; miss_i = (i < n_miss); miss_addr_i = 12'hfff;
      tick(req);
    end
    access_i = 0; miss_i = 0;
  endtask

  task automatic lookup(int a, string req);
    miss_i = 1; miss_addr_i = AW'(a);
    tick(req);
    miss_i = 0;
    tick(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1;
    repeat (3) tick("R1");
    // first boundary: no refinement, phase 0 starts at full width
    boundary(0, "R5");
    // low miss rate walks phase 0 down to the floor
    interval(40, 0, "R6"); boundary(0, "R3");
    interval(40, 1, "R6"); boundary(0, "R3");
    interval(40, 2, "R6"); boundary(0, "R3");
    interval(40, 0, "R6"); boundary(0, "R3");
    // empty interval keeps the count
    boundary(0, "R4");
    // phase 1 fresh at full width, high misses capped at ceiling
    interval(20, 0, "R3"); boundary(1, "R5");
    interval(20, 10, "R4"); boundary(1, "R4");
    interval(32, 0, "R3"); boundary(1, "R3");
    // returning phases restore their stored counts
    interval(32, 0, "R3"); boundary(0, "R5");
    interval(12, 6, "R4"); boundary(1, "R5");
    interval(8, 1, "R6"); boundary(0, "R5");
    // boundary strobe counted in new interval, then saturation
    access_i = 1; miss_i = 1; boundary(2, "R10");
    interval(300, 0, "R10"); boundary(2, "R10");
    // held change during writeback, victim buffer fill with wrap
    interval(40, 0, "R7");
    evict_valid_i = 1;
    for (int k = 0; k < 6; k++) begin
      evict_addr_i = AW'(16 + k); evict_data_i = DW'(16'hA000 + k);
      phase_valid_i = (k == 1); phase_id_i = 2'd2;
      tick(k < 2 ? "R7" : "R8");
    end
    phase_valid_i = 0; evict_valid_i = 0;
    tick("R7"); tick("R7");
    lookup(16, "R8");
    lookup(19, "R9");
    lookup(19, "R9");
    lookup(21, "R9");
    lookup(18, "R8");
    // lookup and writeback in the same cycle
    evict_valid_i = 1; evict_addr_i = 12'h050; evict_data_i = 16'hBEEF;
    miss_i = 1; miss_addr_i = 12'h014; tick("R9");
    evict_valid_i = 0; miss_i = 0; tick("R9");
    lookup(12'h050, "R9");
    lookup(20, "R9");
    // pending change replaced by a later boundary
    interval(20, 10, "R7");
    evict_valid_i = 1; evict_addr_i = 12'h060;
    phase_valid_i = 1; phase_id_i = 2'd3; tick("R7");
    phase_valid_i = 0; tick("R7");
    phase_valid_i = 1; phase_id_i = 2'd0; tick("R7");
    phase_valid_i = 0; evict_valid_i = 0;
    repeat (3) tick("R7");
    repeat (4) tick("R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule